// File: doc/BRIEF.md
# Flash Row Program/Erase Sequencer

This block sits between a processor's register bus and a flash array. It keeps one row of write latches that table-write operations fill. Each table write also records its address, and the recorded low address selects the target row. Software starts an operation in three steps. It writes two fixed key bytes, one after the other. It then writes the control register with the start and write-enable bits set. The block then erases the selected row, or programs the whole row from the latches.

While an operation runs, the block raises a stall signal to the processor for a fixed number of clock cycles. On the final cycle it issues a one-cycle command to the array. It then clears the start bit. The duration is a parameter. The default of 200,000 cycles gives 2 ms at 100 MHz, and a testbench can set a much shorter value. An erased word reads as all ones. Programming clears the array bits wherever the latch bit is zero. After each program command the latches return to all ones.

Top module: `fls_row_seq`

## Requirements
- R1: After reset, the control, low-address and high-address registers read 0 and `cpu_stall` is low. All latch words are all ones, so a program command issued without loading any latch leaves the row unchanged.
- R2: A table write with `tw_hi`=0 sets bits 15:0 of latch word `tw_addr[5:1]` from `tw_data`. A table write with `tw_hi`=1 sets bits 23:16 of that word from `tw_data[7:0]`. Each half is written separately.
- R3: Every accepted table write loads the low-address register (`bus_sel`=1) with `tw_addr[15:0]` and the high-address register (`bus_sel`=2) with `tw_addr[23:16]`. A register write to `bus_sel`=1 also sets the low address. The target row is low-address bits [6 +: ROW_BITS].
- R4: An operation starts only after three register writes in a row, with no other register write between them. The first writes 0x55 to the key register (`bus_sel`=3). The second writes 0xAA to the key register. The third writes the control register (`bus_sel`=0) with bit 15 (start) and bit 14 (write enable) both set.
- R5: Any other register write placed between the key writes, or between the key writes and the control write, re-arms the unlock. The following start request then has no effect: no stall occurs and bit 15 reads 0.
- R6: A control write with bit 15 set and bit 14 clear does not start an operation, even when the key is unlocked. It also uses up the unlock, so an immediately following valid control write does not start either.
- R7: `cpu_stall` is high for exactly OP_CYCLES cycles, starting in the cycle after the accepted start write. Control bit 15 reads 1 during that time and 0 afterwards.
- R8: With control bit 0 = 1, the operation sets every word of the target row to all ones. Other rows are unchanged.
- R9: With control bit 0 = 0, the operation ANDs all latch words into the target row. The latches then return to all ones.
- R10: The key register always reads 0.
- R11: Register writes and table writes made while `cpu_stall` is high are ignored. They change neither the address registers nor the latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select: 0 control, 1 low address, 2 high address, 3 key |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Read data of the selected register |
| tw_en | input | 1 | Table write strobe |
| tw_hi | input | 1 | Table write half: 0 low 16 bits, 1 high 8 bits |
| tw_addr | input | 24 | Table write address |
| tw_data | input | 16 | Table write data |
| cpu_stall | output | 1 | High while an operation runs |
| fl_go | output | 1 | One-cycle command to the flash array |
| fl_erase | output | 1 | Command type: 1 erase, 0 program |
| fl_row | output | ROW_BITS | Target row |
| fl_data | output | ROW_WORDS*WORD_W | Latch contents, word 0 in the low bits |

## Verification
The bench first gives every row of a small 8-row array a distinct starting pattern. It then erases and programs each row in turn, so that a mistake in row decode, word index or half select lands on the wrong word and is caught when the whole array is compared. It reprograms a row without reloading the latches, and programs a partially loaded row. A design that did not reset its latches, or that overwrote the row instead of ANDing into it, would change those rows. It breaks the key pair with an intervening write, reverses the key order, and omits write enable. A design with a loose unlock would stall there. Finally it writes registers and latches during a stall, which exposes a design that does not gate writes while busy through the address readback and a follow-up program.

// File: rtl/fls_pkg.sv
package fls_pkg;
   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_ADRL = 2'd1,
      REG_ADRH = 2'd2,
      REG_KEY  = 2'd3
   } fls_reg_e;

   typedef enum logic [1:0] {
      UL_IDLE = 2'd0,
      UL_HALF = 2'd1,
      UL_OPEN = 2'd2
   } ul_state_e;

   localparam int CTRL_START_BIT = 15;
   localparam int CTRL_WEN_BIT   = 14;
   localparam int CTRL_ERASE_BIT = 0;

   localparam logic [7:0] KEY_FIRST  = 8'h55;
   localparam logic [7:0] KEY_SECOND = 8'hAA;
endpackage

// File: rtl/fls_unlock.sv
module fls_unlock
   import fls_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic       wr_key,
   input  logic [7:0] wr_byte,
   output logic       open_o
);
   ul_state_e state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= UL_IDLE;
      end else if (wr_en) begin
         if (wr_key && wr_byte == KEY_FIRST)
            state <= UL_HALF;
         else if (state == UL_HALF && wr_key && wr_byte == KEY_SECOND)
            state <= UL_OPEN;
         else
            state <= UL_IDLE;
      end
   end

   assign open_o = (state == UL_OPEN);

   AST_OPEN_AFTER_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(open_o) |-> $past(wr_en && wr_key && wr_byte == KEY_SECOND)); // R4

   AST_OTHER_WRITE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (open_o && wr_en && !wr_key) |=> !open_o); // R5
endmodule

// File: rtl/fls_latch.sv
module fls_latch #(
   parameter int WORD_W = 24,
   parameter int WORDS  = 32,
   localparam int IDX_W = $clog2(WORDS),
   localparam int HI_W  = WORD_W - 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic                    wr_hi,
   input  logic [IDX_W-1:0]        wr_idx,
   input  logic [15:0]             wr_data,
   input  logic                    clr,
   output logic [WORDS*WORD_W-1:0] data_o
);
   if (WORD_W <= 16 || WORD_W > 32) begin : g_bad_width
      $error("fls_latch: WORD_W must be in 17..32");
   end

   for (genvar g = 0; g < WORDS; g++) begin : g_word
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= '1;
         end else if (clr) begin
            word_q <= '1;
         end else if (wr_en && wr_idx == IDX_W'(g)) begin
            if (wr_hi)
               word_q[WORD_W-1:16] <= wr_data[HI_W-1:0];
            else
               word_q[15:0] <= wr_data;
         end
      end
      assign data_o[g*WORD_W +: WORD_W] = word_q;
   end

   AST_CLR_SETS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (&data_o)); // R9
endmodule

// File: rtl/fls_timer.sv
module fls_timer #(
   parameter int CYCLES = 200000,
   localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   output logic busy_o,
   output logic done_o
);
   if (CYCLES < 2) begin : g_bad_cycles
      $error("fls_timer: CYCLES must be at least 2");
   end

   localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         cnt    <= '0;
      end else if (busy_o) begin
         if (cnt == LAST) begin
            busy_o <= 1'b0;
            cnt    <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end else if (launch) begin
         busy_o <= 1'b1;
         cnt    <= '0;
      end
   end

   assign done_o = busy_o && (cnt == LAST);

   AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o); // R7

   AST_BUSY_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o) |=> busy_o); // R7
endmodule

// File: rtl/fls_row_seq.sv
module fls_row_seq
   import fls_pkg::*;
#(
   parameter int WORD_W    = 24,
   parameter int ROW_WORDS = 32,
   parameter int ROW_BITS  = 7,
   parameter int OP_CYCLES = 200000
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_we,
   input  logic [1:0]                  bus_sel,
   input  logic [15:0]                 bus_wdata,
   output logic [15:0]                 bus_rdata,
   input  logic                        tw_en,
   input  logic                        tw_hi,
   input  logic [23:0]                 tw_addr,
   input  logic [15:0]                 tw_data,
   output logic                        cpu_stall,
   output logic                        fl_go,
   output logic                        fl_erase,
   output logic [ROW_BITS-1:0]         fl_row,
   output logic [ROW_WORDS*WORD_W-1:0] fl_data
);
   localparam int IDX_W   = $clog2(ROW_WORDS);
   localparam int ROW_LSB = IDX_W + 1;

   if ((1 << IDX_W) != ROW_WORDS) begin : g_bad_words
      $error("fls_row_seq: ROW_WORDS must be a power of two");
   end
   if (ROW_LSB + ROW_BITS > 16) begin : g_bad_rows
      $error("fls_row_seq: row field must fit in the low address");
   end

   logic        busy, done, key_open;
   logic        we_ok, tw_ok, ctrl_wr, launch;
   logic        wen_q, erase_q;
   logic [15:0] adr_lo;
   logic [7:0]  adr_hi;
   fls_reg_e    sel;

   assign sel     = fls_reg_e'(bus_sel);
   assign we_ok   = bus_we && !busy;
   assign tw_ok   = tw_en && !busy;
   assign ctrl_wr = we_ok && sel == REG_CTRL;
   assign launch  = ctrl_wr && bus_wdata[CTRL_START_BIT]
                    && bus_wdata[CTRL_WEN_BIT] && key_open;

   fls_unlock u_unlock (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (we_ok),
      .wr_key  (sel == REG_KEY),
      .wr_byte (bus_wdata[7:0]),
      .open_o  (key_open)
   );

   fls_timer #(.CYCLES(OP_CYCLES)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .launch (launch),
      .busy_o (busy),
      .done_o (done)
   );

   fls_latch #(.WORD_W(WORD_W), .WORDS(ROW_WORDS)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (tw_ok),
      .wr_hi   (tw_hi),
      .wr_idx  (tw_addr[1 +: IDX_W]),
      .wr_data (tw_data),
      .clr     (done && !erase_q),
      .data_o  (fl_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wen_q   <= 1'b0;
         erase_q <= 1'b0;
         adr_lo  <= '0;
         adr_hi  <= '0;
      end else begin
         if (ctrl_wr) begin
            wen_q   <= bus_wdata[CTRL_WEN_BIT];
            erase_q <= bus_wdata[CTRL_ERASE_BIT];
         end
         if (tw_ok) begin
            adr_lo <= tw_addr[15:0];
            adr_hi <= tw_addr[23:16];
         end else if (we_ok && sel == REG_ADRL) begin
            adr_lo <= bus_wdata;
         end else if (we_ok && sel == REG_ADRH) begin
            adr_hi <= bus_wdata[7:0];
         end
      end
   end

   always_comb begin
      unique case (sel)
         REG_CTRL: bus_rdata = {busy, wen_q, 13'd0, erase_q};
         REG_ADRL: bus_rdata = adr_lo;
         REG_ADRH: bus_rdata = {8'd0, adr_hi};
         default:  bus_rdata = 16'd0;
      endcase
   end

   assign cpu_stall = busy;
   assign fl_go     = done;
   assign fl_erase  = erase_q;
   assign fl_row    = adr_lo[ROW_LSB +: ROW_BITS];

   logic unused_bits;
   assign unused_bits = ^{bus_wdata[13:1], tw_addr[0]};

   AST_START_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_stall) |-> $past(key_open && ctrl_wr)); // R4

   AST_NO_WRITE_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_stall && !fl_go) |=> ($stable(adr_lo) && $stable(adr_hi) && $stable(erase_q))); // R11
endmodule

// File: tb/fls_row_seq_test.sv
module fls_row_seq_test;
   localparam int WW = 24;
   localparam int NW = 32;
   localparam int RB = 3;
   localparam int NR = 1 << RB;
   localparam int OPC = 20;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            bus_we = 1'b0;
   logic [1:0]      bus_sel = 2'd0;
   logic [15:0]     bus_wdata = 16'd0;
   logic [15:0]     bus_rdata;
   logic            tw_en = 1'b0;
   logic            tw_hi = 1'b0;
   logic [23:0]     tw_addr = 24'd0;
   logic [15:0]     tw_data = 16'd0;
   logic            cpu_stall, fl_go, fl_erase;
   logic [RB-1:0]   fl_row;
   logic [NW*WW-1:0] fl_data;

   int n_chk = 0;
   int n_err = 0;

   logic [WW-1:0] mem [NR][NW];
   logic [WW-1:0] exp_m [NR][NW];

   always #5 clk = ~clk;

   fls_row_seq #(.WORD_W(WW), .ROW_WORDS(NW), .ROW_BITS(RB), .OP_CYCLES(OPC)) uut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tw_en(tw_en),
      .tw_hi(tw_hi), .tw_addr(tw_addr), .tw_data(tw_data),
      .cpu_stall(cpu_stall), .fl_go(fl_go), .fl_erase(fl_erase),
      .fl_row(fl_row), .fl_data(fl_data)
   );

   // behavioural flash array
   always @(posedge clk) begin
      if (fl_go) begin
         for (int w = 0; w < NW; w++) begin
            if (fl_erase) mem[fl_row][w] <= '1;
            else          mem[fl_row][w] <= mem[fl_row][w] & fl_data[w*WW +: WW];
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic reg_wr(input logic [1:0] s, input logic [15:0] d);
      @(negedge clk);
      bus_sel = s; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic reg_rd(input logic [1:0] s, output logic [15:0] v);
      bus_sel = s;
      #1;
      v = bus_rdata;
   endtask

   task automatic tab_wr(input logic [23:0] a, input logic hi, input logic [15:0] d);
      @(negedge clk);
      tw_addr = a; tw_hi = hi; tw_data = d; tw_en = 1'b1;
      @(negedge clk);
      tw_en = 1'b0;
   endtask

   task automatic unlock();
      reg_wr(2'd3, 16'h0055);
      reg_wr(2'd3, 16'h00AA);
   endtask

   task automatic wait_op(output int cyc);
      cyc = 0;
      while (cpu_stall && cyc < 1000) begin
         cyc++;
         @(negedge clk);
      end
   endtask

   task automatic run_op(input logic erase, input string tag, input int exp_cyc);
      int cyc;
      logic [15:0] v;
      unlock();
      reg_wr(2'd0, erase ? 16'hC001 : 16'hC000);
      reg_rd(2'd0, v);
      chk({tag, " R7 start bit while busy"}, 32'(v[15]), (exp_cyc > 0) ? 32'd1 : 32'd0);
      wait_op(cyc);
      chk({tag, " R7 stall length"}, 32'(cyc), 32'(exp_cyc));
      reg_rd(2'd0, v);
      chk({tag, " R7 start bit cleared"}, 32'(v[15]), 32'd0);
   endtask

   task automatic cmp_all(input string tag);
      int bad = 0;
      for (int r = 0; r < NR; r++)
         for (int w = 0; w < NW; w++)
            if (mem[r][w] !== exp_m[r][w]) bad++;
      chk({tag, " array mismatches"}, 32'(bad), 32'd0);
   endtask

   function automatic logic [WW-1:0] pat(input int r, input int w, input int k);
      logic [15:0] lo;
      logic [7:0]  hi;
      lo = 16'((w * 4099) ^ (r * 257) ^ (k * 1234));
      hi = 8'((r * 17) + w + k * 3);
      return {hi, lo};
   endfunction

   function automatic logic [23:0] waddr(input int r, input int w);
      return {8'h3C, 16'((r << 6) | (w << 1))};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [15:0] v;
      for (int r = 0; r < NR; r++)
         for (int w = 0; w < NW; w++) begin
            mem[r][w]   = pat(r, w, 7) | 24'h010101;
            exp_m[r][w] = pat(r, w, 7) | 24'h010101;
         end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state, R10 key reads zero
      reg_rd(2'd0, v); chk("R1 ctrl after reset", 32'(v), 32'd0);
      reg_rd(2'd1, v); chk("R1 adr_lo after reset", 32'(v), 32'd0);
      reg_rd(2'd2, v); chk("R1 adr_hi after reset", 32'(v), 32'd0);
      chk("R1 stall after reset", 32'(cpu_stall), 32'd0);
      reg_rd(2'd3, v); chk("R10 key after reset", 32'(v), 32'd0);

      // R1 latches all ones: program row 0 unloaded leaves it unchanged
      run_op(1'b0, "R1 unloaded program", OPC);
      cmp_all("R1 unloaded program");

      // sweep every row: erase (R8) then load and program (R2, R3, R9)
      for (int r = 0; r < NR; r++) begin
         reg_wr(2'd1, 16'(r << 6));
         run_op(1'b1, "R8 erase", OPC);
         for (int w = 0; w < NW; w++) exp_m[r][w] = '1;
         cmp_all("R8 erase row");
         for (int w = 0; w < NW; w++) begin
            logic [WW-1:0] p;
            p = pat(r, w, 0);
            tab_wr(waddr(r, w), 1'b0, p[15:0]);
            tab_wr(waddr(r, w), 1'b1, {8'd0, p[23:16]});
         end
         reg_rd(2'd1, v); chk("R3 adr_lo capture", 32'(v), 32'((r << 6) | 62));
         reg_rd(2'd2, v); chk("R3 adr_hi capture", 32'(v), 32'h3C);
         run_op(1'b0, "R9 program", OPC);
         for (int w = 0; w < NW; w++) exp_m[r][w] = exp_m[r][w] & pat(r, w, 0);
         cmp_all("R2 R9 program row");
      end

      // R9 latches reset after program: reprogram row 3 without loading
      reg_wr(2'd1, 16'(3 << 6));
      run_op(1'b0, "R9 reprogram", OPC);
      cmp_all("R9 latches back to ones");

      // R2 partial loads: high half of word 4, low half of word 9, then AND
      tab_wr(waddr(3, 4), 1'b1, 16'h000F);
      tab_wr(waddr(3, 9), 1'b0, 16'h00F0);
      run_op(1'b0, "R2 partial program", OPC);
      exp_m[3][4] = exp_m[3][4] & 24'h0FFFFF;
      exp_m[3][9] = exp_m[3][9] & 24'hFF00F0;
      cmp_all("R2 partial halves AND");

      // R5 broken pair: intervening write
      reg_wr(2'd1, 16'(5 << 6));
      reg_wr(2'd3, 16'h0055);
      reg_wr(2'd1, 16'(5 << 6));
      reg_wr(2'd3, 16'h00AA);
      reg_wr(2'd0, 16'hC001);
      @(negedge clk);
      chk("R5 broken pair no stall", 32'(cpu_stall), 32'd0);
      reg_rd(2'd0, v); chk("R5 broken pair start bit", 32'(v[15]), 32'd0);
      // R5 wrong order
      reg_wr(2'd3, 16'h00AA);
      reg_wr(2'd3, 16'h0055);
      reg_wr(2'd0, 16'hC001);
      @(negedge clk);
      chk("R5 reversed keys no stall", 32'(cpu_stall), 32'd0);
      // R5 write between unlock and start
      unlock();
      reg_wr(2'd2, 16'h003C);
      reg_wr(2'd0, 16'hC001);
      @(negedge clk);
      chk("R5 write after unlock no stall", 32'(cpu_stall), 32'd0);
      cmp_all("R5 array untouched");

      // R6 no write enable, unlock consumed
      unlock();
      reg_wr(2'd0, 16'h8001);
      @(negedge clk);
      chk("R6 start without enable", 32'(cpu_stall), 32'd0);
      reg_wr(2'd0, 16'hC001);
      @(negedge clk);
      chk("R6 unlock consumed", 32'(cpu_stall), 32'd0);
      cmp_all("R6 array untouched");

      // R11 writes during stall ignored
      begin
         int cyc;
         unlock();
         reg_wr(2'd0, 16'hC000);
         tab_wr(waddr(1, 0), 1'b0, 16'h0000);
         reg_wr(2'd1, 16'h0000);
         reg_wr(2'd0, 16'h4001);
         wait_op(cyc);
         reg_rd(2'd1, v); chk("R11 adr_lo kept during stall", 32'(v), 32'(5 << 6));
         reg_rd(2'd0, v); chk("R11 ctrl kept during stall", 32'(v), 32'h4000);
         cmp_all("R11 first op");
         run_op(1'b0, "R11 follow-up", OPC);
         cmp_all("R11 latch not written during stall");
      end

      reg_wr(2'd3, 16'h0055);
      reg_rd(2'd3, v); chk("R10 key write-only", 32'(v), 32'd0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule